// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is an eight-pin general-purpose I/O port that hangs off a simple address/data register bus. Software programs three registers: an output data latch, a per-pin direction register and a write-only per-pin pulldown-inhibit register. From them the block drives each pin's output value, output enable and pulldown enable. Reads return the direction setting, zero for the write-only inhibit register, and a data value that mixes the latch (for output pins) with the synchronized pad level (for input pins).

One global enable input, taken from a device configuration option bit, gates every software-controlled pulldown. A pin's pulldown is active only when that enable is high, the pin's inhibit bit is clear and the pin is configured as an input. Reset makes every pin an input with its pulldown armed and leaves the data latch untouched.

Top module: `gpio_port`

## Requirements
- R1: After reset every direction bit is 0, so `pad_oe` is 0x00 and a read of offset 0x05 returns 0x00.
- R2: A write to offset 0x05 loads the direction register on that clock edge; a 1 bit makes the pin an output (`pad_oe` bit high) and a read of 0x05 returns the value written.
- R3: A write to offset 0x01 loads the data latch on that clock edge and `pad_out` follows it; reset does not change the latch.
- R4: `pad_pd_en` bit i is 1 exactly when `pd_global_en` is 1, inhibit bit i is 0 and direction bit i is 0; an output pin never has its pulldown on.
- R5: Reset clears every inhibit bit, so with `pd_global_en` high all input pins have their pulldown on after reset.
- R6: A write to offset 0x11 loads the inhibit register (1 turns a pin's pulldown off); a read of 0x11 returns 0x00 whatever was written.
- R7: A read of offset 0x01 returns, per bit, the latch value for output pins and the synchronized pad value for input pins.
- R8: A pad level change reaches the data read value through two flip-flops: it is not visible after the first rising edge following the change and is visible after the second.
- R9: A write to any offset other than 0x01, 0x05 and 0x11 changes no register, and a read of such an offset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 5 | Register offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the offset on `bus_addr` (combinational) |
| pd_global_en | input | 1 | Global pulldown enable from the configuration option bit |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_out | output | 8 | Output data to the pads |
| pad_oe | output | 8 | Per-pin output buffer enable |
| pad_pd_en | output | 8 | Per-pin pulldown enable |

## Verification
Register writes land on the rising edge that samples the strobe, and `pad_out`, `pad_oe`, `pad_pd_en` and read data are combinational from the registers, so every register result is due one edge after the strobe; the bench drives on falling edges and samples just after the next falling edge. Pad changes are due two edges after they are applied, and the bench checks both the edge where the old value must still be seen and the edge where the new one must appear. Changes of `pd_global_en` are combinational and are sampled in the same low phase.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned OFF_DATA = 32'h01;
  localparam int unsigned OFF_DIR  = 32'h05;
  localparam int unsigned OFF_INH  = 32'h11;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_INH  = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_core_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_async,
  output logic [WIDTH-1:0] pad_sync
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = pad_async;
    for (int s = 1; s < int'(STAGES); s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign pad_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if      (32'(addr) == OFF_DATA) sel = SEL_DATA;
    else if (32'(addr) == OFF_DIR)  sel = SEL_DIR;
    else if (32'(addr) == OFF_INH)  sel = SEL_INH;
    else                            sel = SEL_NONE;
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] inh_q
);
  logic             data_we, dir_we, inh_we;
  logic [WIDTH-1:0] dir_d, inh_d;

  always_comb begin
    data_we = wr && (sel == SEL_DATA);
    dir_we  = wr && (sel == SEL_DIR);
    inh_we  = wr && (sel == SEL_INH);
    dir_d   = dir_we ? wdata : dir_q;
    inh_d   = inh_we ? wdata : inh_q;
  end

  // Data latch deliberately has no reset: it keeps its contents across reset.
  always_ff @(posedge clk) begin
    if (data_we) data_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      inh_q <= '0;
    end else begin
      dir_q <= dir_d;
      inh_q <= inh_d;
    end
  end

  // R2: direction write lands on the strobe edge
  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_DIR) |=> (dir_q == $past(wdata)));

  // R6: inhibit write lands on the strobe edge
  a_r6_inh_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_INH) |=> (inh_q == $past(wdata)));

  // R3: latch only changes on its own write
  a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel == SEL_DATA) |=> $stable(data_q));

  // R9: unmapped writes leave control registers alone
  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_NONE) |=> ($stable(dir_q) && $stable(inh_q)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic              pd_global_en,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_pd_en
);
  logic             rst_core_n;
  reg_sel_e         sel;
  logic [WIDTH-1:0] data_q, dir_q, inh_q, pad_sync;
  logic [WIDTH-1:0] data_view;

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n)
  );

  gpio_pad_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .pad_async(pad_in), .pad_sync(pad_sync)
  );

  gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .sel(sel)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr(bus_wr), .sel(sel), .wdata(bus_wdata),
    .data_q(data_q), .dir_q(dir_q), .inh_q(inh_q)
  );

  // Per-pin output, enable, pulldown gating and read view
  for (genvar i = 0; i < int'(WIDTH); i++) begin : g_pin
    assign pad_out[i]   = data_q[i];
    assign pad_oe[i]    = dir_q[i];
    assign pad_pd_en[i] = pd_global_en & ~inh_q[i] & ~dir_q[i];
    assign data_view[i] = dir_q[i] ? data_q[i] : pad_sync[i];
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: bus_rdata = data_view;
      SEL_DIR:  bus_rdata = dir_q;
      SEL_INH:  bus_rdata = '0;
      default:  bus_rdata = '0;
    endcase
  end

  // R4: an output pin never carries an active pulldown
  a_r4_no_pd_on_output: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pad_oe & pad_pd_en) == '0);
endmodule

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       pd_global_en;
  logic [7:0] pad_in;
  logic [7:0] pad_out, pad_oe, pad_pd_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_global_en(pd_global_en),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pd_en(pad_pd_en)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    #0.5;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic t_reset_state();
    logic [7:0] r;
    do_reset();
    #0.5;
    check("R1 pad_oe after reset", pad_oe, 8'h00);
    bus_read(5'h05, r);
    check("R1 dir read after reset", r, 8'h00);
    check("R5 pulldowns armed after reset", pad_pd_en, 8'hFF);
  endtask

  task automatic t_direction();
    logic [7:0] r;
    bus_write(5'h05, 8'h5A);
    check("R2 pad_oe after dir write", pad_oe, 8'h5A);
    bus_read(5'h05, r);
    check("R2 dir readback", r, 8'h5A);
    bus_write(5'h05, 8'hF0);
    check("R2 pad_oe second pattern", pad_oe, 8'hF0);
  endtask

  task automatic t_pulldown();
    check("R4 pd off on outputs", pad_pd_en, 8'h0F);
    bus_write(5'h11, 8'h03);
    check("R4 pd with inhibit", pad_pd_en, 8'h0C);
    @(negedge clk) pd_global_en = 1'b0;
    #0.5;
    check("R4 global disable", pad_pd_en, 8'h00);
    @(negedge clk) pd_global_en = 1'b1;
    #0.5;
    check("R4 global re-enable", pad_pd_en, 8'h0C);
  endtask

  task automatic t_inh_read();
    logic [7:0] r;
    bus_write(5'h11, 8'hFF);
    bus_read(5'h11, r);
    check("R6 inhibit read is zero", r, 8'h00);
    check("R6 all inhibited", pad_pd_en, 8'h00);
  endtask

  task automatic t_data_mux();
    logic [7:0] r;
    @(negedge clk) pad_in = 8'h3C;
    repeat (3) @(negedge clk);
    bus_write(5'h01, 8'hA5);
    check("R3 pad_out follows latch", pad_out, 8'hA5);
    bus_read(5'h01, r);
    check("R7 mixed data read", r, 8'hAC);
  endtask

  task automatic t_sync_latency();
    logic [7:0] r;
    bus_addr = 5'h01;
    @(negedge clk) pad_in = 8'hC3;
    @(negedge clk);
    bus_read(5'h01, r);
    check("R8 not visible after one edge", r, 8'hAC);
    @(negedge clk);
    bus_read(5'h01, r);
    check("R8 visible after two edges", r, 8'hA3);
  endtask

  task automatic t_unmapped();
    logic [7:0] r;
    bus_write(5'h02, 8'h0F);
    bus_write(5'h1F, 8'h00);
    bus_write(5'h10, 8'h00);
    check("R9 dir unchanged", pad_oe, 8'hF0);
    check("R9 data unchanged", pad_out, 8'hA5);
    check("R9 inhibit unchanged", pad_pd_en, 8'h00);
    bus_read(5'h02, r);
    check("R9 unmapped read zero", r, 8'h00);
  endtask

  task automatic t_reset_keeps_data();
    do_reset();
    #0.5;
    check("R3 latch kept through reset", pad_out, 8'hA5);
    check("R1 outputs off after reset", pad_oe, 8'h00);
    check("R5 inhibit cleared by reset", pad_pd_en, 8'hFF);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    pd_global_en = 1'b1; pad_in = 8'h00;
    t_reset_state();
    t_direction();
    t_pulldown();
    t_inh_read();
    t_data_mux();
    t_sync_latency();
    t_unmapped();
    t_reset_keeps_data();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule